// File: doc/BRIEF.md
# SPI Master Interrupt Status and Mask Unit

This unit gathers the FIFO fill conditions and the error events of an SPI master into one status word and folds that word, through a mask, into a single level-sensitive interrupt request. Two status bits are sticky error records: one for a receive overflow and one for a transmit underflow. They are set by one-cycle event pulses from the datapath and are cleared by software writing ones to the status offset. The other four live bits come from comparing the current transmit and receive FIFO levels against the full depth and against two programmable thresholds.

Software never writes the mask directly. A write to the enable offset sets every mask bit that carries a one, a write to the disable offset clears them, and the mask offset only reads the result. This lets independent handlers switch their own sources on and off without a read-modify-write. The register port is a plain single-cycle write strobe plus an independent combinational read address; the FIFOs and the shifter sit outside this unit.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After reset the mask is all zero, both sticky bits are clear, both thresholds read 1, and `irq` is low.
- R2: Status bit 2 (transmit below threshold) is 1 exactly when `tx_level` is less than the transmit threshold (offset 0x28); status bit 3 (transmit full) is 1 exactly when `tx_level` equals the FIFO depth (128 by default).
- R3: Status bit 4 (receive at threshold) is 1 exactly when `rx_level` is greater than or equal to the receive threshold (offset 0x2C); status bit 5 (receive full) is 1 exactly when `rx_level` equals the FIFO depth.
- R4: Status bit 0 becomes 1 in the cycle after an `rx_ovf_evt` pulse and status bit 6 in the cycle after a `tx_udf_evt` pulse; each then holds until cleared.
- R5: A write to the status offset 0x04 clears each sticky bit whose data bit is 1, leaves those with a 0 data bit unchanged, and has no effect on bits 1 to 5; writing all ones clears both sticky bits.
- R6: When an event pulse and a clearing write for the same sticky bit arrive in the same cycle, the bit is 1 afterwards.
- R7: A write to offset 0x08 sets the mask bits where the data (bits 6..0) is 1, a write to 0x0C clears them, other mask bits are unchanged, and offset 0x10 reads the mask in bits 6..0; writing all ones to 0x0C clears the whole mask.
- R8: `irq` is high, in the same cycle, exactly when some status bit and its mask bit are both 1.
- R9: Status bit 1 (mode fault) always reads 0; offsets 0x28 and 0x2C read back the thresholds last written (low 8 bits of the data).
- R10: Writes to offset 0x10 or to any address outside 0x04, 0x08, 0x0C, 0x28 and 0x2C change no register; reads of unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the combinational read |
| rd_data | output | 32 | Read data for `rd_addr` |
| tx_level | input | 8 | Current transmit FIFO occupancy, 0 to depth |
| rx_level | input | 8 | Current receive FIFO occupancy, 0 to depth |
| rx_ovf_evt | input | 1 | One-cycle pulse: receive overflow occurred |
| tx_udf_evt | input | 1 | One-cycle pulse: transmit underflow occurred |
| irq | output | 1 | Active-high level interrupt request |

## Verification
The level flags are swept with occupancies placed just below, at and above each threshold and at the full depth, after moving both thresholds off their reset value, which separates an off-by-one compare or a swapped direction from a correct one. Sticky bits are tried with lone pulses, with clearing writes that carry zeros, ones and all ones, and with a pulse landing on the clearing write, which tells set priority apart from clear priority. Mask traffic mixes enable and disable writes over partly overlapping bit sets plus writes to the read-only and unused offsets, so a mask that is overwritten instead of set or cleared bitwise is exposed. A long stretch of random writes, levels and pulses then compares every cycle against a behavioural model.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
    localparam int NUM_SRC = 7;

    // status bit positions (decoded by software)
    localparam int B_RX_OVF  = 0;
    localparam int B_MODEF   = 1;
    localparam int B_TX_NF   = 2;
    localparam int B_TX_FULL = 3;
    localparam int B_RX_NE   = 4;
    localparam int B_RX_FULL = 5;
    localparam int B_TX_UDF  = 6;

    // register offsets
    localparam int OFF_STATUS = 'h04;
    localparam int OFF_ENA    = 'h08;
    localparam int OFF_DIS    = 'h0C;
    localparam int OFF_MASK   = 'h10;
    localparam int OFF_TX_THR = 'h28;
    localparam int OFF_RX_THR = 'h2C;
endpackage

// File: rtl/spi_irq_level.sv
module spi_irq_level #(
    parameter int DEPTH = 128,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_thr,
    input  logic [LVL_W-1:0] rx_thr,
    output logic             tx_below,
    output logic             tx_full,
    output logic             rx_reached,
    output logic             rx_full
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    always_comb begin
        tx_below   = tx_level < tx_thr;
        tx_full    = tx_level == FULL_LVL;
        rx_reached = rx_level >= rx_thr;
        rx_full    = rx_level == FULL_LVL;
    end
endmodule

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    typedef struct packed {
        logic [N-1:0] flag;
    } sticky_t;

    sticky_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clear first, then set, so a same-cycle event survives
        st_d.flag = (st_q.flag & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{flag: '0};
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    for (genvar k = 0; k < N; k++) begin : g_chk
        // R4: a recorded event holds while nothing clears it
        a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.flag[k] && !clr_i[k]) |=> st_q.flag[k]);
        // R6: a pulse always leaves the bit set, clear or not
        a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> st_q.flag[k]);
        // R5: a clear without a pulse empties the bit
        a_r5_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !set_i[k]) |=> !st_q.flag[k]);
    end
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
    import spi_irq_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int LVL_W   = 8,
    parameter int THR_RST = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [NUM_SRC-1:0] status_clr_o,
    output logic [LVL_W-1:0]   tx_thr_o,
    output logic [LVL_W-1:0]   rx_thr_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic [LVL_W-1:0]   tx_thr;
        logic [LVL_W-1:0]   rx_thr;
    } regs_t;

    regs_t rg_d, rg_q;

    logic               ena_stb, dis_stb, stat_stb, txt_stb, rxt_stb;
    logic [NUM_SRC-1:0] wr_bits;
    logic [LVL_W-1:0]   wr_thr;
    logic               unused_wr_hi;

    assign wr_bits      = wr_data[NUM_SRC-1:0];
    assign wr_thr       = wr_data[LVL_W-1:0];
    assign unused_wr_hi = ^wr_data;

    always_comb begin
        ena_stb  = wr_en && (wr_addr == ADDR_W'(OFF_ENA));
        dis_stb  = wr_en && (wr_addr == ADDR_W'(OFF_DIS));
        stat_stb = wr_en && (wr_addr == ADDR_W'(OFF_STATUS));
        txt_stb  = wr_en && (wr_addr == ADDR_W'(OFF_TX_THR));
        rxt_stb  = wr_en && (wr_addr == ADDR_W'(OFF_RX_THR));

        rg_d = rg_q;
        if (ena_stb) rg_d.mask   = rg_q.mask | wr_bits;
        if (dis_stb) rg_d.mask   = rg_q.mask & ~wr_bits;
        if (txt_stb) rg_d.tx_thr = wr_thr;
        if (rxt_stb) rg_d.rx_thr = wr_thr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rg_q <= '{mask: '0, tx_thr: LVL_W'(THR_RST), rx_thr: LVL_W'(THR_RST)};
        else
            rg_q <= rg_d;
    end

    assign mask_o       = rg_q.mask;
    assign tx_thr_o     = rg_q.tx_thr;
    assign rx_thr_o     = rg_q.rx_thr;
    assign status_clr_o = stat_stb ? wr_bits : '0;

    // R7: enable sets every requested bit
    a_r7_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ena_stb |=> ((rg_q.mask & $past(wr_bits)) == $past(wr_bits)));
    // R7: disable clears every requested bit
    a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        dis_stb |=> ((rg_q.mask & $past(wr_bits)) == '0));
    // R10: no enable or disable strobe, no mask change
    a_r10_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(ena_stb || dis_stb) |=> $stable(rg_q.mask));
    // R9: thresholds change only on their own writes
    a_r9_thr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(txt_stb || rxt_stb) |=> ($stable(rg_q.tx_thr) && $stable(rg_q.rx_thr)));
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
    import spi_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 128,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              rx_ovf_evt,
    input  logic              tx_udf_evt,
    output logic              irq
);
    logic [NUM_SRC-1:0] mask, status_clr, status;
    logic [LVL_W-1:0]   tx_thr, rx_thr;
    logic               tx_below, tx_full, rx_reached, rx_full;
    logic [1:0]         sticky;

    spi_irq_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W), .THR_RST(1)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mask_o(mask), .status_clr_o(status_clr),
        .tx_thr_o(tx_thr), .rx_thr_o(rx_thr)
    );

    spi_irq_level #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_level (
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_thr(tx_thr), .rx_thr(rx_thr),
        .tx_below(tx_below), .tx_full(tx_full),
        .rx_reached(rx_reached), .rx_full(rx_full)
    );

    spi_irq_sticky #(.N(2)) u_sticky (
        .clk(clk), .rst_n(rst_n),
        .set_i({tx_udf_evt, rx_ovf_evt}),
        .clr_i({status_clr[B_TX_UDF], status_clr[B_RX_OVF]}),
        .flag_o(sticky)
    );

    always_comb begin
        status            = '0;
        status[B_RX_OVF]  = sticky[0];
        status[B_MODEF]   = 1'b0;       // no slave mode, never faults
        status[B_TX_NF]   = tx_below;
        status[B_TX_FULL] = tx_full;
        status[B_RX_NE]   = rx_reached;
        status[B_RX_FULL] = rx_full;
        status[B_TX_UDF]  = sticky[1];
    end

    assign irq = |(status & mask);

    always_comb begin
        rd_data = '0;
        if      (rd_addr == ADDR_W'(OFF_STATUS)) rd_data = DATA_W'(status);
        else if (rd_addr == ADDR_W'(OFF_MASK))   rd_data = DATA_W'(mask);
        else if (rd_addr == ADDR_W'(OFF_TX_THR)) rd_data = DATA_W'(tx_thr);
        else if (rd_addr == ADDR_W'(OFF_RX_THR)) rd_data = DATA_W'(rx_thr);
    end

    // R8: nothing enabled, nothing requested
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
    // R3: a full receive FIFO always meets any reachable threshold
    a_r3_full_meets_thr: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == LVL_W'(DEPTH) && rx_thr <= LVL_W'(DEPTH)) |-> status[B_RX_NE]);
    // R4: an overflow pulse is visible in the next cycle
    a_r4_ovf_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf_evt |=> status[B_RX_OVF]);
endmodule

// File: tb/tb_spi_irq_ctrl.sv
module tb_spi_irq_ctrl;
    localparam int DEPTH = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  tx_level = '0;
    logic [7:0]  rx_level = '0;
    logic        rx_ovf_evt = 1'b0;
    logic        tx_udf_evt = 1'b0;
    logic        irq;

    always #2 clk = ~clk;

    spi_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tx_level(tx_level), .rx_level(rx_level),
        .rx_ovf_evt(rx_ovf_evt), .tx_udf_evt(tx_udf_evt), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    int m_mask = 0, m_ovf = 0, m_udf = 0, m_txthr = 1, m_rxthr = 1;

    function automatic int m_status();
        int s = 0;
        if (m_ovf != 0)                  s |= 1;
        if (int'(tx_level) < m_txthr)    s |= 4;
        if (int'(tx_level) == DEPTH)     s |= 8;
        if (int'(rx_level) >= m_rxthr)   s |= 16;
        if (int'(rx_level) == DEPTH)     s |= 32;
        if (m_udf != 0)                  s |= 64;
        return s;
    endfunction

    function automatic int m_read(input int a);
        case (a)
            'h04: return m_status();
            'h10: return m_mask;
            'h28: return m_txthr;
            'h2C: return m_rxthr;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, compare, then advance model at posedge
    task automatic cyc(input bit we, input int wa, input int wd, input int ra,
                       input int txl, input int rxl, input bit po, input bit pu,
                       input string tag);
        int exp_rd, exp_irq, d;
        wr_en = we; wr_addr = 8'(wa); wr_data = 32'(wd); rd_addr = 8'(ra);
        tx_level = 8'(txl); rx_level = 8'(rxl); rx_ovf_evt = po; tx_udf_evt = pu;
        #1;
        exp_rd  = m_read(ra);
        exp_irq = ((m_status() & m_mask) != 0) ? 1 : 0;
        chk(int'(rd_data) == exp_rd, {tag, " rd_data"}, int'(rd_data), exp_rd);
        chk(int'(irq) == exp_irq, {tag, " irq"}, int'(irq), exp_irq);
        @(posedge clk);
        d = wd;
        if (we) begin
            case (wa)
                'h04: begin
                    if ((d & 1) != 0)  m_ovf = 0;
                    if ((d & 64) != 0) m_udf = 0;
                end
                'h08: m_mask = m_mask | (d & 'h7F);
                'h0C: m_mask = m_mask & ~d & 'h7F;
                'h28: m_txthr = d & 'hFF;
                'h2C: m_rxthr = d & 'hFF;
                default: ;
            endcase
        end
        if (po) m_ovf = 1;
        if (pu) m_udf = 1;
        @(negedge clk);
    endtask

    task automatic idle_rd(input int ra, input int txl, input int rxl, input string tag);
        cyc(0, 0, 0, ra, txl, rxl, 0, 0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, levels chosen so no level flag is set
        idle_rd('h04, 1, 0, "R1");
        idle_rd('h10, 1, 0, "R1");
        idle_rd('h28, 1, 0, "R1");
        idle_rd('h2C, 1, 0, "R1");

        // R2 transmit flags around a moved threshold and the full depth
        cyc(1, 'h28, 32, 'h28, 0, 0, 0, 0, "R9");
        idle_rd('h28, 0, 0, "R9");
        for (int l = 30; l <= 34; l++) idle_rd('h04, l, 0, "R2");
        idle_rd('h04, 127, 0, "R2");
        idle_rd('h04, 128, 0, "R2");

        // R3 receive flags
        cyc(1, 'h2C, 'h1_05, 'h2C, 0, 0, 0, 0, "R9");
        idle_rd('h2C, 0, 0, "R9");
        for (int l = 3; l <= 7; l++) idle_rd('h04, 0, l, "R3");
        idle_rd('h04, 0, 128, "R3");

        // R4 sticky set and hold
        cyc(0, 0, 0, 'h04, 40, 0, 1, 0, "R4");
        for (int i = 0; i < 3; i++) idle_rd('h04, 40, 0, "R4");
        cyc(0, 0, 0, 'h04, 40, 0, 0, 1, "R4");
        idle_rd('h04, 40, 0, "R4");

        // R5 clearing writes
        cyc(1, 'h04, 'h3E, 'h04, 40, 0, 0, 0, "R5");
        idle_rd('h04, 40, 0, "R5");
        cyc(1, 'h04, 'h01, 'h04, 40, 0, 0, 0, "R5");
        idle_rd('h04, 40, 0, "R5");
        cyc(0, 0, 0, 'h04, 40, 0, 1, 0, "R5");
        cyc(1, 'h04, -1, 'h04, 40, 0, 0, 0, "R5");
        idle_rd('h04, 40, 0, "R5");

        // R6 event beats clear
        cyc(1, 'h04, -1, 'h04, 40, 0, 1, 1, "R6");
        idle_rd('h04, 40, 0, "R6");
        cyc(1, 'h04, 'h41, 'h04, 40, 0, 0, 0, "R6");

        // R7 / R8 mask traffic
        cyc(1, 'h08, 'h15, 'h10, 40, 0, 0, 0, "R7");
        idle_rd('h10, 40, 0, "R7");
        idle_rd('h10, 40, 6, "R8");
        cyc(1, 'h08, 'h44, 'h10, 40, 6, 0, 0, "R7");
        cyc(1, 'h0C, 'h14, 'h10, 40, 6, 0, 0, "R7");
        idle_rd('h10, 40, 6, "R7");
        cyc(0, 0, 0, 'h10, 10, 0, 0, 1, "R8");
        idle_rd('h04, 10, 0, "R8");
        cyc(1, 'h0C, -1, 'h10, 10, 0, 0, 0, "R7");
        idle_rd('h10, 10, 0, "R7");
        idle_rd('h04, 10, 0, "R8");

        // R10 ignored writes and unused reads
        cyc(1, 'h10, 'h7F, 'h10, 10, 0, 0, 0, "R10");
        idle_rd('h10, 10, 0, "R10");
        cyc(1, 'h00, -1, 'h00, 10, 0, 0, 0, "R10");
        cyc(1, 'h14, -1, 'h24, 10, 0, 0, 0, "R10");
        idle_rd('h10, 10, 0, "R10");
        idle_rd('h28, 10, 0, "R10");
        idle_rd('h2C, 10, 0, "R10");
        idle_rd('h04, 10, 0, "R9");

        // mixed random traffic against the model
        for (int i = 0; i < 2000; i++) begin
            int sel, wa, ra;
            sel = int'($urandom_range(0, 7));
            case (sel)
                0: wa = 'h04; 1: wa = 'h08; 2: wa = 'h0C; 3: wa = 'h10;
                4: wa = 'h28; 5: wa = 'h2C; 6: wa = 'h00; default: wa = 'h08;
            endcase
            sel = int'($urandom_range(0, 4));
            case (sel)
                0: ra = 'h04; 1: ra = 'h10; 2: ra = 'h28; 3: ra = 'h2C; default: ra = 'h04;
            endcase
            cyc(($urandom_range(0, 2) == 0), wa, int'($urandom_range(0, 255)), ra,
                int'($urandom_range(0, 128)), int'($urandom_range(0, 128)),
                ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0), "R8");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule